// File: doc/BRIEF.md
# Static Memory Bank Timing Controller

This block sits between a simple CPU request bus and external asynchronous memories or peripherals. It serves three chip-select banks. Each bank has a window of the 28-bit address space, set in 1 MB pages, and its own strobe timing. When a request arrives, the block finds the bank whose window contains the address. It then drives the address, the chip select, the read or write enable and a data strobe in a programmed sequence. It can stretch the strobe while the device holds its active-low wait line. At the end it returns a one-cycle ready. A request that falls in no enabled window is answered at once with an error flag, and no external strobe moves.

Each bank has one 32-bit configuration word, written through a small register port. The word holds the exclusive end page and the start page. It also holds three setup/hold counts of 0 to 6 cycles and an access code. Access code 0 switches the bank off. Codes 1 to 6 give 2 to 7 strobe cycles. The timing of the selected bank is frozen when the request is accepted. A configuration write made during an access therefore shapes only later accesses.

The sequencer has six states. IDLE waits for a request. ADDR is address setup, with no chip select. CSSET is chip-select setup. STROBE is the enable and strobe phase. HOLD keeps the chip select after the strobe. RESP gives the ready pulse. The transitions are:
- IDLE to RESP on a miss.
- IDLE to ADDR, CSSET or STROBE on a hit. The target is the first phase whose count is non-zero.
- ADDR to CSSET or STROBE when its count runs out.
- CSSET to STROBE.
- STROBE to HOLD, or to RESP when the hold count is 0. This happens once the count is spent and no wait is pending.
- HOLD to RESP.
- RESP to IDLE.

Top module: `smc_top`

## Requirements
- R1: After reset the configuration words read back as 0x08003000, 0x0C083000 and 0x100C3000 at byte offsets 0x0, 0x4 and 0x8. After reset all chip selects, the read enable, the write enable and the strobe are high, and ready is low.
- R2: Bits [1:0] and [15:14] of every configuration word always read as zero. A write to an offset other than 0x0, 0x4 or 0x8, including a misaligned one, changes no word.
- R3: The configuration word holds the end page in [31:24] and the start page in [23:16]. A request hits bank n when start <= addr[27:20] < end and the bank is enabled. Among overlapping banks the lowest-numbered one wins. Only that bank's chip select (mem_cs_n bit n) goes low.
- R4: A bank whose access code, bits [13:11], is 0 is never selected. A request that falls in its window alone is a miss.
- R5: A miss raises rsp_ready together with rsp_err in the first cycle after acceptance. No chip select or strobe goes low.
- R6: The address is driven for the address setup count, bits [7:5], before the chip select falls.
- R7: The chip select leads the strobe by the count in bits [4:2]. The strobe then lasts for the access code plus one cycles. During the strobe, mem_oe_n is low for reads and mem_we_n is low for writes, and both are never low at once.
- R8: After the strobe the chip select is held for the count in bits [10:8]. rsp_ready is then high for exactly one cycle, with every chip select high.
- R9: A low on mem_wait_n sampled at the end of the second-to-last strobe cycle extends the strobe. Each further low sample adds one more cycle. A strobe of N cycles therefore lasts N plus the number of consecutive low samples.
- R10: On a read, rsp_rdata holds the value on mem_rdata in the final strobe cycle.
- R11: A configuration write made while an access is running does not alter that access. The next access uses the new value.
- R12: A field code of 7 acts as 6 cycles in the setup and hold fields and as 7 strobe cycles in the access field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data at cfg_addr |
| req_valid | input | 1 | Request present; held until rsp_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Request byte address |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Miss flag, valid with rsp_ready |
| rsp_rdata | output | 32 | Read data, valid with rsp_ready |
| mem_addr | output | 28 | External address |
| mem_cs_n | output | 3 | Active-low chip selects, one per bank |
| mem_oe_n | output | 1 | Active-low read enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_strobe_n | output | 1 | Active-low data strobe |
| mem_wdata | output | 32 | External write data |
| mem_rdata | input | 32 | External read data |
| mem_wait_n | input | 1 | Active-low wait from the device |

## Verification
A configuration write to the bank being accessed can land in the same cycle as that access's strobe sequence. The bench provokes this by issuing a register write two cycles after acceptance, which changes the setup, access and hold counts of the active bank. It then requires that the running access keeps the old phase lengths and the following access shows the new ones. Wait stretching can also coincide with the final strobe cycle in which read data is captured. The bench pulls wait low across that boundary and checks that the returned data is the value presented in the last, extended cycle.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam int CFG_W  = 32;
    localparam int PAGE_W = 8;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CSSET,
        ST_STROBE,
        ST_HOLD,
        ST_RESP
    } smc_state_e;

    typedef struct packed {
        logic [PAGE_W-1:0] end_pg;
        logic [PAGE_W-1:0] start_pg;
        logic [CODE_W-1:0] acc_code;
        logic [CODE_W-1:0] hold_code;
        logic [CODE_W-1:0] asu_code;
        logic [CODE_W-1:0] csu_code;
    } bank_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] asu;
        logic [CNT_W-1:0] csu;
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] hold;
    } timing_t;

    function automatic logic [CFG_W-1:0] pack_cfg(bank_cfg_t c);
        return {c.end_pg, c.start_pg, 2'b00, c.acc_code, c.hold_code,
                c.asu_code, c.csu_code, 2'b00};
    endfunction

    function automatic bank_cfg_t unpack_cfg(logic [CFG_W-1:0] w);
        bank_cfg_t c;
        c.end_pg    = w[31:24];
        c.start_pg  = w[23:16];
        c.acc_code  = w[13:11];
        c.hold_code = w[10:8];
        c.asu_code  = w[7:5];
        c.csu_code  = w[4:2];
        return c;
    endfunction

    function automatic bank_cfg_t reset_cfg(int idx);
        bank_cfg_t c;
        c.end_pg    = PAGE_W'(8 + 4 * idx);
        c.start_pg  = (idx == 0) ? '0 : PAGE_W'(4 + 4 * idx);
        c.acc_code  = 3'd6;
        c.hold_code = '0;
        c.asu_code  = '0;
        c.csu_code  = '0;
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] setup_cycles(logic [CODE_W-1:0] code);
        return (code == 3'd7) ? CNT_W'(6) : CNT_W'(code);
    endfunction

    function automatic logic [CNT_W-1:0] access_cycles(logic [CODE_W-1:0] code);
        return (code == 3'd7) ? CNT_W'(7) : CNT_W'(code) + CNT_W'(1);
    endfunction

    function automatic timing_t to_timing(bank_cfg_t c);
        timing_t t;
        t.asu  = setup_cycles(c.asu_code);
        t.csu  = setup_cycles(c.csu_code);
        t.hold = setup_cycles(c.hold_code);
        t.acc  = access_cycles(c.acc_code);
        return t;
    endfunction

endpackage

// File: rtl/smc_regs.sv
module smc_regs
    import smc_pkg::*;
#(
    parameter int NBANK  = 3,
    parameter int CFG_AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_rdata,
    output bank_cfg_t [NBANK-1:0] bank_cfg
);

    localparam int IDX_W = CFG_AW - 2;

    bank_cfg_t [NBANK-1:0] bank_q;
    logic [IDX_W-1:0]      idx;
    logic                  aligned;
    logic                  rsvd_unused;

    assign idx         = cfg_addr[CFG_AW-1:2];
    assign aligned     = (cfg_addr[1:0] == 2'b00);
    assign rsvd_unused = ^{cfg_wdata[15:14], cfg_wdata[1:0]};

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= reset_cfg(g);
            end else if (cfg_we && aligned && idx == IDX_W'(g)) begin
                bank_q[g] <= unpack_cfg(cfg_wdata);
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (aligned && idx == IDX_W'(i)) begin
                cfg_rdata = pack_cfg(bank_q[i]);
            end
        end
    end

    assign bank_cfg = bank_q;

    // R2: a misaligned write never reaches any bank word
    p_stray_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !aligned) |=> $stable(bank_q));

    // R2: reserved bit positions never carry a one on the read port
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1:0] == 2'b00) && (cfg_rdata[15:14] == 2'b00));

endmodule

// File: rtl/smc_decode.sv
module smc_decode
    import smc_pkg::*;
#(
    parameter int NBANK = 3,
    parameter int BW    = 2
) (
    input  bank_cfg_t [NBANK-1:0] bank_cfg,
    input  logic [PAGE_W-1:0]     page,
    output logic                  hit,
    output logic [BW-1:0]         sel,
    output timing_t               tim
);

    logic [NBANK-1:0] in_win;

    for (genvar g = 0; g < NBANK; g++) begin : g_win
        assign in_win[g] = (bank_cfg[g].acc_code != '0) &&
                           (page >= bank_cfg[g].start_pg) &&
                           (page <  bank_cfg[g].end_pg);
    end

    // Scan from the top down so the lowest-numbered bank is the last to win.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        tim = '0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (in_win[i]) begin
                hit = 1'b1;
                sel = BW'(i);
                tim = to_timing(bank_cfg[i]);
            end
        end
    end

endmodule

// File: rtl/smc_fsm.sv
module smc_fsm
    import smc_pkg::*;
#(
    parameter int NBANK = 3,
    parameter int BW    = 2,
    parameter int AW    = 28,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic             hit,
    input  logic [BW-1:0]    sel,
    input  timing_t          tim,
    output logic             rsp_ready,
    output logic             rsp_err,
    output logic [DW-1:0]    rsp_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic [NBANK-1:0] mem_cs_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic             mem_strobe_n,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_wait_n
);

    smc_state_e       state, state_d;
    logic [CNT_W-1:0] cnt, cnt_d;
    timing_t          tim_q;
    logic [BW-1:0]    bank_q;
    logic             write_q;
    logic             err_q;
    logic             wait_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic [DW-1:0]    rdata_q;
    logic             accept;
    logic             strobe_last;

    assign accept      = (state == ST_IDLE) && req_valid;
    assign strobe_last = (state == ST_STROBE) && (cnt == '0) && !wait_q;

    // Next-state and phase counter
    always_comb begin
        state_d = state;
        cnt_d   = (cnt != '0) ? cnt - CNT_W'(1) : cnt;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!hit) begin
                        state_d = ST_RESP;
                    end else if (tim.asu != '0) begin
                        state_d = ST_ADDR;
                        cnt_d   = tim.asu - CNT_W'(1);
                    end else if (tim.csu != '0) begin
                        state_d = ST_CSSET;
                        cnt_d   = tim.csu - CNT_W'(1);
                    end else begin
                        state_d = ST_STROBE;
                        cnt_d   = tim.acc - CNT_W'(1);
                    end
                end
            end
            ST_ADDR: begin
                if (cnt == '0) begin
                    if (tim_q.csu != '0) begin
                        state_d = ST_CSSET;
                        cnt_d   = tim_q.csu - CNT_W'(1);
                    end else begin
                        state_d = ST_STROBE;
                        cnt_d   = tim_q.acc - CNT_W'(1);
                    end
                end
            end
            ST_CSSET: begin
                if (cnt == '0) begin
                    state_d = ST_STROBE;
                    cnt_d   = tim_q.acc - CNT_W'(1);
                end
            end
            ST_STROBE: begin
                if (strobe_last) begin
                    if (tim_q.hold != '0) begin
                        state_d = ST_HOLD;
                        cnt_d   = tim_q.hold - CNT_W'(1);
                    end else begin
                        state_d = ST_RESP;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt == '0) begin
                    state_d = ST_RESP;
                end
            end
            ST_RESP: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register and the request snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            tim_q   <= '0;
            bank_q  <= '0;
            write_q <= 1'b0;
            err_q   <= 1'b0;
            wait_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            if (accept) begin
                tim_q   <= tim;
                bank_q  <= sel;
                write_q <= req_write;
                err_q   <= !hit;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state == ST_STROBE && cnt <= CNT_W'(1)) begin
                wait_q <= !mem_wait_n;
            end else begin
                wait_q <= 1'b0;
            end
            if (strobe_last && !write_q) begin
                rdata_q <= mem_rdata;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        mem_cs_n     = '1;
        mem_oe_n     = 1'b1;
        mem_we_n     = 1'b1;
        mem_strobe_n = 1'b1;
        rsp_ready    = 1'b0;
        rsp_err      = 1'b0;
        unique case (state)
            ST_CSSET, ST_HOLD: begin
                for (int i = 0; i < NBANK; i++) begin
                    if (bank_q == BW'(i)) mem_cs_n[i] = 1'b0;
                end
            end
            ST_STROBE: begin
                for (int i = 0; i < NBANK; i++) begin
                    if (bank_q == BW'(i)) mem_cs_n[i] = 1'b0;
                end
                mem_strobe_n = 1'b0;
                mem_oe_n     = write_q;
                mem_we_n     = !write_q;
            end
            ST_RESP: begin
                rsp_ready = 1'b1;
                rsp_err   = err_q;
            end
            default: begin
            end
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign rsp_rdata = rdata_q;

    // R5: a miss answers in the next cycle with the error flag and no select
    p_miss_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit) |=> (rsp_ready && rsp_err && (&mem_cs_n)));

    // R8: ready is a single-cycle pulse
    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

    // R9: a pending wait sample keeps the strobe asserted one more cycle
    p_wait_stretch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && cnt == '0 && wait_q) |=> !mem_strobe_n);

    // R7: read and write enables never overlap, strobe only inside a select
    p_enable_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    p_strobe_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_strobe_n |-> !(&mem_cs_n));

    // R11: the timing snapshot does not move once an access is under way
    p_timing_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(tim_q));

endmodule

// File: rtl/smc_top.sv
module smc_top
    import smc_pkg::*;
#(
    parameter int NBANK  = 3,
    parameter int AW     = 28,
    parameter int DW     = 32,
    parameter int CFG_AW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_ready,
    output logic             rsp_err,
    output logic [DW-1:0]    rsp_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic [NBANK-1:0] mem_cs_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic             mem_strobe_n,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_wait_n
);

    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;

    bank_cfg_t [NBANK-1:0] bank_cfg;
    logic                  hit;
    logic [BW-1:0]         sel;
    timing_t               tim;

    smc_regs #(.NBANK(NBANK), .CFG_AW(CFG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .bank_cfg  (bank_cfg)
    );

    smc_decode #(.NBANK(NBANK), .BW(BW)) u_decode (
        .bank_cfg (bank_cfg),
        .page     (req_addr[AW-1 -: PAGE_W]),
        .hit      (hit),
        .sel      (sel),
        .tim      (tim)
    );

    smc_fsm #(.NBANK(NBANK), .BW(BW), .AW(AW), .DW(DW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .hit          (hit),
        .sel          (sel),
        .tim          (tim),
        .rsp_ready    (rsp_ready),
        .rsp_err      (rsp_err),
        .rsp_rdata    (rsp_rdata),
        .mem_addr     (mem_addr),
        .mem_cs_n     (mem_cs_n),
        .mem_oe_n     (mem_oe_n),
        .mem_we_n     (mem_we_n),
        .mem_strobe_n (mem_strobe_n),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .mem_wait_n   (mem_wait_n)
    );

    // R3: at most one chip select is low at any time
    p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R8: ready never coincides with an asserted chip select
    p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> (&mem_cs_n));

endmodule

// File: tb/smc_top_tb.sv
module smc_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [27:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_ready, rsp_err;
    logic [31:0] rsp_rdata;
    logic [27:0] mem_addr;
    logic [2:0]  mem_cs_n;
    logic        mem_oe_n, mem_we_n, mem_strobe_n;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_wait_n = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] cfg_m [3];

    localparam logic [31:0] MASK = 32'hFFFF_3FFC;

    always #10 clk = ~clk;

    smc_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_strobe_n(mem_strobe_n), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_wait_n(mem_wait_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int setup_c(logic [2:0] c);
        return (c == 3'd7) ? 6 : int'(c);
    endfunction

    function automatic int acc_c(logic [2:0] c);
        return (c == 3'd7) ? 7 : int'(c) + 1;
    endfunction

    function automatic int exp_bank(logic [7:0] pg);
        for (int b = 0; b < 3; b++) begin
            if (cfg_m[b][13:11] != 3'd0 && pg >= cfg_m[b][23:16] && pg < cfg_m[b][31:24])
                return b;
        end
        return -1;
    endfunction

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a[1:0] == 2'b00 && a[3:2] < 2'd3) cfg_m[a[3:2]] = d & MASK;
    endtask

    task automatic cfg_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #2;
        chk(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    task automatic access(input bit wr, input logic [27:0] a, input logic [31:0] wd,
                          input int w, input bit midw, input logic [3:0] mid_a,
                          input logic [31:0] mid_d, input string tag);
        int b, ts, tc, ta, th, n, pre, csu, sj, hold;
        bit rdy, ok_bank, ok_dir, err;
        logic [31:0] rd;
        b = exp_bank(a[27:20]);
        ts = 0; tc = 0; ta = 0; th = 0;
        if (b >= 0) begin
            ts = setup_c(cfg_m[b][7:5]);
            tc = setup_c(cfg_m[b][4:2]);
            th = setup_c(cfg_m[b][10:8]);
            ta = acc_c(cfg_m[b][13:11]);
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        mem_wait_n = 1'b1;
        n = 0; pre = 0; csu = 0; sj = 0; hold = 0;
        rdy = 0; ok_bank = 1; ok_dir = 1; err = 0; rd = '0;
        while (!rdy && n < 100) begin
            @(negedge clk);
            n++;
            if (midw) begin
                if (n == 2) begin
                    cfg_we = 1'b1; cfg_addr = mid_a; cfg_wdata = mid_d;
                end else if (n == 3) begin
                    cfg_we = 1'b0;
                end
            end
            if (rsp_ready) begin
                rdy = 1; err = rsp_err; rd = rsp_rdata;
                if (mem_cs_n != 3'b111) ok_bank = 0;
            end else if (&mem_cs_n) begin
                if (sj == 0) pre++;
                if (mem_addr != a) ok_dir = 0;
            end else begin
                if (b < 0 || mem_cs_n != ~(3'b001 << b)) ok_bank = 0;
                if (mem_addr != a) ok_dir = 0;
                if (!mem_strobe_n) begin
                    sj++;
                    if (wr && !(mem_we_n == 1'b0 && mem_oe_n == 1'b1 && mem_wdata == wd)) ok_dir = 0;
                    if (!wr && !(mem_oe_n == 1'b0 && mem_we_n == 1'b1)) ok_dir = 0;
                    mem_rdata = {a[15:0], 16'(sj)};
                    mem_wait_n = !(sj >= ta - 1 && sj < ta - 1 + w);
                end else begin
                    mem_wait_n = 1'b1;
                    if (sj == 0) csu++;
                    else hold++;
                end
            end
        end
        req_valid = 1'b0;
        mem_wait_n = 1'b1;
        cfg_we = 1'b0;
        if (midw) cfg_m[mid_a[3:2]] = mid_d & MASK;
        if (b < 0) begin
            chk(err == 1'b1 && n == 1, {tag, " R5 miss answered at once with error"}, n, 1);
            chk(sj == 0 && ok_bank, {tag, " R5 no strobe on miss"}, sj, 0);
        end else begin
            chk(err == 1'b0, {tag, " R3 hit has no error"}, err, 0);
            chk(ok_bank, {tag, " R3 only the chosen select low"}, b, b);
            chk(pre == ts, {tag, " R6 address setup cycles"}, pre, ts);
            chk(csu == tc, {tag, " R7 select-to-strobe cycles"}, csu, tc);
            chk(sj == ta + w, {tag, " R7 R9 strobe length"}, sj, ta + w);
            chk(ok_dir, {tag, " R7 enable direction, address and data"}, ok_dir, 1);
            chk(hold == th, {tag, " R8 hold cycles"}, hold, th);
            chk(n == ts + tc + ta + w + th + 1, {tag, " R8 ready cycle"}, n, ts + tc + ta + w + th + 1);
            if (!wr) chk(rd == {a[15:0], 16'(ta + w)}, {tag, " R10 captured read data"},
                         rd, {a[15:0], 16'(ta + w)});
        end
        @(negedge clk);
        chk(rsp_ready == 1'b0, {tag, " R8 ready lasts one cycle"}, rsp_ready, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        cfg_m[0] = 32'h0800_3000;
        cfg_m[1] = 32'h0C08_3000;
        cfg_m[2] = 32'h100C_3000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(mem_cs_n == 3'b111 && mem_oe_n && mem_we_n && mem_strobe_n && !rsp_ready,
            "R1 idle outputs after reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_strobe_n, rsp_ready}, 32'h7E);
        cfg_check(4'h0, 32'h0800_3000, "R1 reset word bank0");
        cfg_check(4'h4, 32'h0C08_3000, "R1 reset word bank1");
        cfg_check(4'h8, 32'h100C_3000, "R1 reset word bank2");

        // R2 reserved bits and stray offsets
        cfg_write(4'h8, 32'hFFFF_FFFF);
        cfg_check(4'h8, 32'hFFFF_3FFC, "R2 reserved bits read zero");
        cfg_write(4'h8, 32'h100C_3000);
        cfg_write(4'hC, 32'h1234_5678);
        cfg_write(4'h6, 32'h1F00_0404);
        cfg_check(4'h4, 32'h0C08_3000, "R2 stray write leaves bank1");
        cfg_check(4'h8, 32'h100C_3000, "R2 stray write leaves bank2");
        cfg_check(4'hC, 32'h0, "R2 unmapped offset reads zero");

        // Default timing read and write in bank1, miss above all windows
        access(1'b0, 28'h090_1234, 32'h0, 0, 1'b0, 4'h0, 32'h0, "dflt");
        access(1'b1, 28'h0B0_0010, 32'hCAFE_F00D, 0, 1'b0, 4'h0, 32'h0, "dflt");
        access(1'b0, 28'h150_0000, 32'h0, 0, 1'b0, 4'h0, 32'h0, "R5");

        // R3 overlap: bank1 covers pages 0..0x0F, page 5 still goes to bank0
        cfg_write(4'h4, 32'h1000_0D24);
        access(1'b0, 28'h050_0040, 32'h0, 0, 1'b0, 4'h0, 32'h0, "R3");
        access(1'b0, 28'h0A0_0040, 32'h0, 0, 1'b0, 4'h0, 32'h0, "R3");

        // R4 disabled bank0: page 5 falls through to bank1, then bank1 off too
        cfg_write(4'h0, 32'h0800_0000);
        access(1'b0, 28'h050_0044, 32'h0, 0, 1'b0, 4'h0, 32'h0, "R4");
        cfg_write(4'h4, 32'h1000_0000);
        access(1'b0, 28'h050_0044, 32'h0, 0, 1'b0, 4'h0, 32'h0, "R4");
        chk(exp_bank(8'h05) == -1, "R4 model agrees page 5 unmapped", 0, 0);

        // R12 all-seven codes, then R9 wait stretch on that bank
        cfg_write(4'h0, 32'h0400_3FFC);
        access(1'b0, 28'h010_0100, 32'h0, 0, 1'b0, 4'h0, 32'h0, "R12");
        access(1'b0, 28'h010_0104, 32'h0, 2, 1'b0, 4'h0, 32'h0, "R9");
        access(1'b1, 28'h020_0108, 32'h5A5A_0001, 1, 1'b0, 4'h0, 32'h0, "R9");

        // R11 config write lands in the middle of an access to the same bank
        access(1'b0, 28'h010_0200, 32'h0, 0, 1'b1, 4'h0, 32'h0400_0924, "R11");
        access(1'b0, 28'h010_0204, 32'h0, 0, 1'b0, 4'h0, 32'h0, "R11");

        // Constrained random windows, timings, waits and directions
        for (int r = 0; r < 60; r++) begin
            if (r % 10 == 0) begin
                for (int b = 0; b < 3; b++) begin
                    logic [7:0] st, en;
                    st = 8'($urandom_range(0, 30));
                    en = 8'($urandom_range(32'(st) + 1, 31));
                    cfg_write(4'(4 * b), {en, st, 2'b00, 3'($urandom_range(0, 7)),
                              3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                              3'($urandom_range(0, 7)), 2'b00});
                end
            end
            begin
                logic [27:0] a;
                int bb, w;
                a = {8'($urandom_range(0, 31)), 20'($urandom)};
                bb = exp_bank(a[27:20]);
                w = 0;
                if (bb >= 0 && acc_c(cfg_m[bb][13:11]) >= 3) w = $urandom_range(0, 3);
                access(1'($urandom), a, $urandom, w, 1'b0, 4'h0, 32'h0, "rnd");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule